// File: doc/BRIEF.md
# Saturating Fractional Multiply and Absolute Unit

This unit works on signed fractional operands N bits wide. A code stands for a value from -1 up to 1 - 2^-(N-1), both ends included. An op select picks one of two operations. The first is a fractional multiply, which builds the full 2N-bit signed product and keeps the N bits that line up with the fractional point. The second is an absolute value of operand A. Each operation has one input that cannot be represented. For the multiply it is -1 times -1, which is +1. For the absolute value it is the absolute value of -1. In both cases the unit gives the largest positive fraction instead of letting the result wrap to -1, and it raises an overflow flag.

Every other input gives a bit-exact truncated result, with no rounding. A valid strobe captures the operands. The result and the flag appear on registered outputs on the clock edge that samples the strobe. The outputs keep their values until the next strobe.

Top module: `sat_frac_unit`

## Requirements
- R1: After reset, `res_q` is 0, `ovf_q` is 0 and `res_vld_q` is 0.
- R2: `op_sel` = 0 selects multiply. The result is bits [2N-2:N-1] of the 2N-bit signed product a*b, truncated.
- R3: For multiply with a = b = most negative code (only MSB set), the result is the maximum positive code (MSB clear, all other bits set) and `ovf_q` is 1.
- R4: `op_sel` = 1 selects absolute value of `a`. `b` is ignored. A non-negative `a` passes through unchanged and a negative `a` gives its two's complement negation.
- R5: For absolute value with `a` = most negative code, the result is the maximum positive code and `ovf_q` is 1.
- R6: `ovf_q` is 1 exactly when saturation replaced the natural result. Otherwise it is 0.
- R7: A strobe on `in_vld` in cycle t gives `res_vld_q` = 1 and the new result after that edge. `res_vld_q` is 0 after an edge where `in_vld` was low.
- R8: When `in_vld` is low, `res_q` and `ovf_q` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_vld | input | 1 | Operand strobe |
| op_sel | input | 1 | 0 selects multiply, 1 selects absolute value |
| a | input | N | Operand A, signed fraction |
| b | input | N | Operand B, signed fraction (used only by multiply) |
| res_q | output | N | Registered result |
| ovf_q | output | 1 | Registered saturation flag |
| res_vld_q | output | 1 | Result valid, one cycle after the strobe |

## Verification
The bench goes after the two corners that cannot be represented: (-1)*(-1) and |-1|. A design that wraps either one returns the most negative code, and a design that forgets the flag leaves `ovf_q` low. Near neighbours of these corners are also applied: -1 times the maximum, the maximum times the maximum, -1 times the smallest negative step, and |-1 + LSB|. A design that tests the corner with too broad a compare would flag these or saturate them by mistake. Sign mixes and zero operands expose a wrong slice of the product or an unsigned multiply. Absolute-value ops with a nonzero `b` show whether `b` leaks into the result. Idle cycles show whether the result register holds its value.

// File: rtl/sat_frac_pkg.sv
package sat_frac_pkg;
  typedef enum logic {OP_MUL = 1'b0, OP_ABS = 1'b1} op_e;
endpackage

// File: rtl/sat_frac_mul.sv
module sat_frac_mul #(
  parameter int N = 16
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] y,
  output logic         sat
);
  localparam logic [N-1:0] MINV = {1'b1, {(N-1){1'b0}}};
  localparam logic [N-1:0] MAXV = {1'b0, {(N-1){1'b1}}};

  function automatic logic [N-1:0] frac_slice(input logic [N-1:0] x, input logic [N-1:0] z);
    logic signed [2*N-1:0] p;
    p = $signed({{N{x[N-1]}}, x}) * $signed({{N{z[N-1]}}, z});
    return p[2*N-2:N-1];
  endfunction

  logic [N-1:0] raw;
  assign raw = frac_slice(a, b);
  assign sat = (a == MINV) && (b == MINV);
  assign y   = sat ? MAXV : raw;

  always_comb begin
    AST_MUL_CORNER_WRAPS: assert (!sat || raw == MINV) else $error("corner"); // R3
  end
endmodule

// File: rtl/sat_frac_abs.sv
module sat_frac_abs #(
  parameter int N = 16
) (
  input  logic [N-1:0] a,
  output logic [N-1:0] y,
  output logic         sat
);
  localparam int G = N + 1;
  localparam logic [G-1:0] GMAX = {2'b00, {(N-1){1'b1}}};

  function automatic logic [G-1:0] guarded_abs(input logic [N-1:0] x);
    logic [G-1:0] g;
    g = {x[N-1], x};
    return g[G-1] ? (~g + 1'b1) : g;
  endfunction

  logic [G-1:0] mag;
  assign mag = guarded_abs(a);
  assign sat = (mag > GMAX);
  assign y   = sat ? GMAX[N-1:0] : mag[N-1:0];

  always_comb begin
    AST_ABS_NONNEG: assert (y[N-1] == 1'b0) else $error("abs sign"); // R4
  end
endmodule

// File: rtl/sat_frac_unit.sv
module sat_frac_unit
  import sat_frac_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic         op_sel,
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] res_q,
  output logic         ovf_q,
  output logic         res_vld_q
);
  localparam logic [N-1:0] MAXV = {1'b0, {(N-1){1'b1}}};

  logic [N-1:0] mul_y, abs_y, nxt_y;
  logic         mul_sat, abs_sat, nxt_sat;

  sat_frac_mul #(.N(N)) u_mul (.a(a), .b(b), .y(mul_y), .sat(mul_sat));
  sat_frac_abs #(.N(N)) u_abs (.a(a), .y(abs_y), .sat(abs_sat));

  always_comb begin
    if (op_e'(op_sel) == OP_ABS) begin
      nxt_y = abs_y; nxt_sat = abs_sat;
    end else begin
      nxt_y = mul_y; nxt_sat = mul_sat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0; ovf_q <= 1'b0; res_vld_q <= 1'b0;
    end else begin
      res_vld_q <= in_vld;
      if (in_vld) begin
        res_q <= nxt_y; ovf_q <= nxt_sat;
      end
    end
  end

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> res_vld_q) else $error("vld"); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(res_q) && $stable(ovf_q)) else $error("hold"); // R8
  AST_OVF_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> res_q == MAXV) else $error("ovf"); // R6
  AST_MUL_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !op_sel && a == {1'b1, {(N-1){1'b0}}} && b == {1'b1, {(N-1){1'b0}}})
      |=> ovf_q && res_q == MAXV) else $error("mulsat"); // R3
  AST_ABS_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && op_sel && a == {1'b1, {(N-1){1'b0}}}) |=> ovf_q && res_q == MAXV)
    else $error("abssat"); // R5
endmodule

// File: tb/sim_sat_frac_unit.sv
module sim_sat_frac_unit;
  localparam int N = 16;
  localparam time TCLK = 10ns;
  localparam logic [N-1:0] MN = {1'b1, {(N-1){1'b0}}};
  localparam logic [N-1:0] MX = {1'b0, {(N-1){1'b1}}};

  logic clk = 0, rst_n = 0, in_vld = 0, op_sel = 0;
  logic [N-1:0] a = '0, b = '0;
  logic [N-1:0] res_q;
  logic ovf_q, res_vld_q;
  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct { logic [N-1:0] y; logic o; string tag; } exp_t;
  exp_t q[$];

  always #(TCLK/2) clk = ~clk;

  sat_frac_unit #(.N(N)) u0 (.clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op_sel(op_sel),
    .a(a), .b(b), .res_q(res_q), .ovf_q(ovf_q), .res_vld_q(res_vld_q));

  function automatic exp_t model(input logic op, input logic [N-1:0] x, input logic [N-1:0] z, input string tag);
    exp_t e; longint sx, sz, pr;
    sx = longint'($signed(x)); sz = longint'($signed(z));
    e.tag = tag; e.o = 0;
    if (!op) begin
      pr = sx * sz;
      if (pr >= (longint'(1) << (2*N-2))) begin e.y = MX; e.o = 1; end
      else e.y = N'(pr >>> (N-1));
    end else begin
      if (sx < 0) sx = -sx;
      if (sx > longint'(MX)) begin e.y = MX; e.o = 1; end
      else e.y = N'(sx);
    end
    return e;
  endfunction

  task automatic drive(input logic op, input logic [N-1:0] x, input logic [N-1:0] z, input string tag);
    @(negedge clk);
    in_vld = 1; op_sel = op; a = x; b = z;
    q.push_back(model(op, x, z, tag));
    @(negedge clk);
    in_vld = 0; a = $urandom; b = $urandom; op_sel = $urandom;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s act=%h exp=%h", tag, act, exp); end
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk); #1;
      if (res_vld_q && rst_n) begin
        if (q.size() == 0) chk(0, "R7 unexpected valid", 0, 0);
        else begin
          exp_t e; e = q.pop_front();
          chk(res_q == e.y, e.tag, res_q, e.y);
          chk(ovf_q == e.o, {e.tag, " R6 flag"}, N'(ovf_q), N'(e.o));
        end
      end
    end
  end

  initial begin : watchdog
    #(TCLK * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog act=hang exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] held;
    #(TCLK * 2 + 3ns);
    chk(res_q == 0 && !ovf_q && !res_vld_q, "R1 reset", res_q, 0);
    rst_n = 1;
    drive(0, MN, MN, "R3 mul -1*-1");
    drive(1, MN, 16'h1234, "R5 abs -1");
    drive(0, MN, MX, "R2 mul -1*max");
    drive(0, MX, MX, "R2 mul max*max");
    drive(0, MN, 16'hFFFF, "R2 mul -1*-lsb");
    drive(0, 16'h4000, 16'h4000, "R2 mul .5*.5");
    drive(0, 16'hC000, 16'h4000, "R2 mul -.5*.5");
    drive(0, 16'h0000, MN, "R2 mul 0*-1");
    drive(0, 16'h8001, 16'h8001, "R2 mul near corner");
    drive(1, 16'h8001, MN, "R4 abs -1+lsb");
    drive(1, 16'h1234, MN, "R4 abs pos b ignored");
    drive(1, 16'hFFFF, 16'h0000, "R4 abs -lsb");
    drive(1, 16'h0000, 16'hFFFF, "R4 abs zero");
    for (int i = 0; i < 200; i++) begin
      logic [N-1:0] x, z; logic op;
      x = $urandom; z = $urandom; op = $urandom;
      if (i % 20 == 0) x = MN;
      drive(op, x, z, op ? "R4 abs random" : "R2 mul random");
    end
    drive(0, MN, MN, "R3 mul corner again");
    @(negedge clk); held = res_q;
    repeat (5) @(negedge clk);
    chk(res_q == held && ovf_q && !res_vld_q, "R8 hold idle", res_q, held);
    #1;
    chk(q.size() == 0, "R7 all results seen", N'(q.size()), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule